// File: doc/BRIEF.md
# Data Memory Effective Address Generator

This block turns the file-register operand of an 8-bit microcontroller instruction into a 12-bit linear data-memory address. It takes the 8-bit file field, the access-select bit, a 4-bit bank number and three 12-bit pointer registers. A configuration input turns on the extended instruction set. The result is latched into an output register when an instruction issues.

With the extended set off, an operand either uses the bank number as its upper address bits or goes through the access bank. The access bank maps low offsets to the bottom of memory and high offsets to the special-function region at the top. With the extended set on, an access-bank operand whose field is 5Fh or less becomes a literal offset. That offset is added to the third pointer register, and a flag output marks the access. Indirect accesses through any pointer pass that pointer straight through in both modes. Instructions with no memory operand leave the output register untouched.

Top module: `data_addr_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `ea_o` to 000h and `lit_o` to 0.
- R2: `ea_o` and `lit_o` load only at a rising edge where `issue_i` = 1 and `no_mem_i` = 0. At any other edge outside reset, both keep their value.
- R3: With `ind_i` = 0, `xinst_i` = 1, `acc_i` = 0 and `fa_i` ≤ 5Fh, the loaded `ea_o` is `ptr2_i` + `fa_i` (the field zero-extended) and `lit_o` = 1.
- R4: With `ind_i` = 0 and `acc_i` = 1, the loaded `ea_o` is {`bank_i`, `fa_i`} and `lit_o` = 0, whatever the value of `xinst_i`.
- R5: With `ind_i` = 0, `acc_i` = 0 and `fa_i` ≥ 60h, the loaded `ea_o` is {Fh, `fa_i`} and `lit_o` = 0, whatever the value of `xinst_i`.
- R6: With `ind_i` = 0, `xinst_i` = 0, `acc_i` = 0 and `fa_i` ≤ 5Fh, the loaded `ea_o` is {0h, `fa_i`} and `lit_o` = 0.
- R7: With `ind_i` = 1, the loaded `ea_o` is the pointer chosen by `ind_sel_i` (00: `ptr0_i`, 01: `ptr1_i`, 10 or 11: `ptr2_i`) and `lit_o` = 0. The values of `xinst_i`, `acc_i`, `fa_i` and `bank_i` have no effect.
- R8: The R3 sum is unsigned and wraps modulo 4096. For example, `ptr2_i` = FFFh with `fa_i` = 5Fh gives 05Eh, and no carry is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Instruction issue strobe |
| no_mem_i | input | 1 | Issued instruction has no memory operand |
| xinst_i | input | 1 | Extended instruction set enabled |
| acc_i | input | 1 | Access-select bit (0 = access bank) |
| ind_i | input | 1 | Operand is an indirect access through a pointer |
| ind_sel_i | input | 2 | Pointer chosen for indirect access |
| fa_i | input | 8 | File address field of the instruction |
| bank_i | input | 4 | Bank number |
| ptr0_i | input | 12 | First pointer register |
| ptr1_i | input | 12 | Second pointer register |
| ptr2_i | input | 12 | Third pointer register (base for literal offsets) |
| ea_o | output | 12 | Registered effective address |
| lit_o | output | 1 | Registered flag: address came from the literal-offset path |

## Verification
The hardest cases are at the 5Fh/60h boundary with the extended set on and the access bank selected. Only there does one step of the field move the address from the pointer-relative region to the top of memory. A second hard case is a pointer-relative sum that crosses FFFh. Uniform random fields seldom land on both conditions at once, so directed cases cover 5Fh and 60h in both modes and set the third pointer to FFFh. The random phase biases `fa_i` toward the boundary and sets `xinst_i` on half of the issues.

// File: rtl/data_addr_gen.sv
module data_addr_gen #(
  parameter int ADDR_W  = 12,
  parameter int FA_W    = 8,
  parameter int IDX_MAX = 'h5F,
  parameter int LOW_MAX = 'h5F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic              no_mem_i,
  input  logic              xinst_i,
  input  logic              acc_i,
  input  logic              ind_i,
  input  logic [1:0]        ind_sel_i,
  input  logic [FA_W-1:0]   fa_i,
  input  logic [ADDR_W-FA_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] ptr0_i,
  input  logic [ADDR_W-1:0] ptr1_i,
  input  logic [ADDR_W-1:0] ptr2_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              lit_o
);

  localparam int BANK_W = ADDR_W - FA_W;

  logic              load;
  logic              fa_low;
  logic              use_idx;
  logic [ADDR_W-1:0] ptr_pick;
  logic [ADDR_W-1:0] idx_sum;
  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] ea_nxt;

  assign load    = issue_i & ~no_mem_i;
  assign fa_low  = (int'(fa_i) <= LOW_MAX);
  assign use_idx = ~ind_i & xinst_i & ~acc_i & (int'(fa_i) <= IDX_MAX);
  assign idx_sum = ptr2_i + {{BANK_W{1'b0}}, fa_i};
  assign acc_addr = fa_low ? {{BANK_W{1'b0}}, fa_i} : {{BANK_W{1'b1}}, fa_i};

  always_comb begin
    case (ind_sel_i)
      2'b00:   ptr_pick = ptr0_i;
      2'b01:   ptr_pick = ptr1_i;
      default: ptr_pick = ptr2_i;
    endcase
  end

  always_comb begin
    if (ind_i)        ea_nxt = ptr_pick;
    else if (use_idx) ea_nxt = idx_sum;
    else if (acc_i)   ea_nxt = {bank_i, fa_i};
    else              ea_nxt = acc_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_o  <= '0;
      lit_o <= 1'b0;
    end else if (load) begin
      ea_o  <= ea_nxt;
      lit_o <= use_idx;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (ea_o == '0 && !lit_o)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(issue_i && !no_mem_i) |=> ($stable(ea_o) && $stable(lit_o))); // R2

  AST_INDEXED: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !no_mem_i && !ind_i && xinst_i && !acc_i && int'(fa_i) <= IDX_MAX)
    |=> (lit_o && ea_o == ADDR_W'($past(ptr2_i) + {{BANK_W{1'b0}}, $past(fa_i)}))); // R3

  AST_BANKED: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !no_mem_i && !ind_i && acc_i)
    |=> (!lit_o && ea_o == {$past(bank_i), $past(fa_i)})); // R4

  AST_SFR_HIGH: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !no_mem_i && !ind_i && !acc_i && int'(fa_i) > LOW_MAX)
    |=> (!lit_o && ea_o[ADDR_W-1 -: BANK_W] == {BANK_W{1'b1}})); // R5

  AST_LOW_PLAIN: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !no_mem_i && !ind_i && !xinst_i && !acc_i && int'(fa_i) <= LOW_MAX)
    |=> (!lit_o && ea_o[ADDR_W-1 -: BANK_W] == '0)); // R6

  AST_INDIRECT: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !no_mem_i && ind_i && ind_sel_i == 2'b00)
    |=> (!lit_o && ea_o == $past(ptr0_i))); // R7

endmodule

// File: tb/tb_data_addr_gen.sv
`timescale 1ns/1ps
module tb_data_addr_gen;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, issue_i = 1'b0, no_mem_i = 1'b0, xinst_i = 1'b0, acc_i = 1'b0, ind_i = 1'b0;
  logic [1:0]  ind_sel_i = '0;
  logic [7:0]  fa_i = '0;
  logic [3:0]  bank_i = '0;
  logic [11:0] ptr0_i = '0, ptr1_i = '0, ptr2_i = '0;
  logic [11:0] ea_o;
  logic        lit_o;

  data_addr_gen dut (
    .clk(clk), .rst(rst), .issue_i(issue_i), .no_mem_i(no_mem_i), .xinst_i(xinst_i),
    .acc_i(acc_i), .ind_i(ind_i), .ind_sel_i(ind_sel_i), .fa_i(fa_i), .bank_i(bank_i),
    .ptr0_i(ptr0_i), .ptr1_i(ptr1_i), .ptr2_i(ptr2_i), .ea_o(ea_o), .lit_o(lit_o)
  );

  int checks = 0, failures = 0;
  logic [11:0] exp_ea = '0;
  logic        exp_lit = 1'b0;
  bit          done = 1'b0;

  function automatic string path_tag(input logic x, a, ind, input logic [7:0] fa,
                                     input logic [11:0] p2);
    if (ind) return "R7";
    if (!a && x && fa <= 8'h5F) return ({1'b0, p2} + {5'b0, fa} > 13'hFFF) ? "R8" : "R3";
    if (a) return "R4";
    if (fa >= 8'h60) return "R5";
    return "R6";
  endfunction

  function automatic logic [12:0] model(input logic x, a, ind, input logic [1:0] sel,
                                        input logic [7:0] fa, input logic [3:0] bk,
                                        input logic [11:0] p0, p1, p2);
    if (ind) return {1'b0, (sel == 2'b00) ? p0 : (sel == 2'b01) ? p1 : p2};
    if (!a && x && fa <= 8'h5F) return {1'b1, 12'(p2 + {4'h0, fa})};
    if (a) return {1'b0, bk, fa};
    if (fa >= 8'h60) return {1'b0, 4'hF, fa};
    return {1'b0, 4'h0, fa};
  endfunction

  task automatic check(input string tag);
    checks++;
    if (ea_o !== exp_ea || lit_o !== exp_lit) begin
      failures++;
      $display("FAIL %s: ea=%03h lit=%0b expected ea=%03h lit=%0b", tag, ea_o, lit_o, exp_ea, exp_lit);
    end
  endtask

  task automatic step(input logic iss, nm, x, a, ind, input logic [1:0] sel,
                      input logic [7:0] fa, input logic [3:0] bk,
                      input logic [11:0] p0, p1, p2);
    string tag;
    @(negedge clk);
    issue_i = iss; no_mem_i = nm; xinst_i = x; acc_i = a; ind_i = ind; ind_sel_i = sel;
    fa_i = fa; bank_i = bk; ptr0_i = p0; ptr1_i = p1; ptr2_i = p2;
    if (iss && !nm) begin
      {exp_lit, exp_ea} = model(x, a, ind, sel, fa, bk, p0, p1, p2);
      tag = path_tag(x, a, ind, fa, p2);
    end else tag = "R2";
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; issue_i = 1'b0;
    @(posedge clk); #1;
    exp_ea = '0; exp_lit = 1'b0;
    check("R1");
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd5150));
    do_reset();
    // R3 plain indexed, then boundaries R5/R6
    step(1, 0, 1, 0, 0, 2'b00, 8'h10, 4'h3, 12'h111, 12'h222, 12'h300);
    step(1, 0, 1, 0, 0, 2'b00, 8'h5F, 4'h3, 12'h111, 12'h222, 12'h300);
    step(1, 0, 1, 0, 0, 2'b00, 8'h60, 4'h3, 12'h111, 12'h222, 12'h300);
    step(1, 0, 0, 0, 0, 2'b00, 8'h5F, 4'h3, 12'h111, 12'h222, 12'h300);
    step(1, 0, 0, 0, 0, 2'b00, 8'h60, 4'h3, 12'h111, 12'h222, 12'h300);
    // R8 wrap
    step(1, 0, 1, 0, 0, 2'b00, 8'h5F, 4'h3, 12'h111, 12'h222, 12'hFFF);
    step(1, 0, 1, 0, 0, 2'b00, 8'h01, 4'h3, 12'h111, 12'h222, 12'hFFF);
    // R4 banked in both modes
    step(1, 0, 1, 1, 0, 2'b00, 8'h20, 4'hA, 12'h111, 12'h222, 12'h300);
    step(1, 0, 0, 1, 0, 2'b00, 8'hC4, 4'h5, 12'h111, 12'h222, 12'h300);
    // R7 indirect, each selector, ignoring fa/acc/xinst
    step(1, 0, 1, 0, 1, 2'b00, 8'h05, 4'h1, 12'hABC, 12'h222, 12'h300);
    step(1, 0, 0, 1, 1, 2'b01, 8'h05, 4'h1, 12'hABC, 12'hDEF, 12'h300);
    step(1, 0, 1, 0, 1, 2'b10, 8'h05, 4'h1, 12'hABC, 12'hDEF, 12'h777);
    step(1, 0, 1, 0, 1, 2'b11, 8'h05, 4'h1, 12'hABC, 12'hDEF, 12'h778);
    // R2 holds: no-memory operand, and no issue
    step(1, 0, 1, 0, 0, 2'b00, 8'h10, 4'h3, 12'h111, 12'h222, 12'h300);
    step(1, 1, 0, 1, 0, 2'b00, 8'h99, 4'h9, 12'h111, 12'h222, 12'h300);
    step(0, 0, 0, 1, 1, 2'b01, 8'h99, 4'h9, 12'h111, 12'h222, 12'h300);
    // R1 reset after a load
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] fa;
      fa = ($urandom % 4 == 0) ? 8'(8'h5C + $urandom % 8) : 8'($urandom);
      step(($urandom % 8) != 0, ($urandom % 6) == 0, $urandom % 2, ($urandom % 3) == 0,
           ($urandom % 5) == 0, 2'($urandom), fa, 4'($urandom),
           12'($urandom), 12'($urandom), ($urandom % 4 == 0) ? 12'hFF0 + 12'($urandom % 16) : 12'($urandom));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule